// File: doc/BRIEF.md
# Firmware ROM Window Decoder

This block decides whether a memory access targets the firmware ROM and, if so, asserts the ROM chip select. Accesses arrive from two kinds of bus master. Wide-bus masters present a 32-bit address; narrow-bus masters present a 24-bit address. For a wide-bus hit the decoder raises a forward flag. It also drives the narrow-bus upper address lines [23:17] that the forwarded cycle will carry, including the bits that are forced high to keep the cycle clear of ordinary memory on the narrow bus.

The 128 KB ROM window sits just below 1 MB, at 0x000E0000–0x000FFFFF, and is split into a lower 64 KB half and an upper 64 KB half. Wide masters also see the window mirrored at the top of the 4 GB space and at the top of the 4 GB−1 MB space. Each half keeps the same enable in every mirror. The lower half has one enable bit. The upper half opens only when every one of its gate bits is set. An extended 384 KB region just below the top mirror is visible to wide masters only, and only when its own enable is set.

A wide burst read into enabled ROM space raises a disconnect request, so the burst ends after its first data phase. Narrow-bus cycles are never forwarded. Their chip select is purely combinational and is blocked during refresh and DMA cycles. The configuration inputs are captured on each clock; the decode itself is combinational from the captured enables and the current address.

Top module: `rom_win_dec`

## Requirements
- R1: After reset all enables are clear, so no address from either bus asserts rom_cs_o or fwd_o until configuration is captured.
- R2: A valid wide access to 0x000E0000–0x000EFFFF, 0xFFFE0000–0xFFFEFFFF or 0xFFEE0000–0xFFEEFFFF asserts rom_cs_o and fwd_o exactly when the lower-half enable is set.
- R3: A valid wide access to 0x000F0000–0x000FFFFF, 0xFFFF0000–0xFFFFFFFF or 0xFFEF0000–0xFFEFFFFF asserts rom_cs_o and fwd_o only when every bit of cfg_hi_gate_i is 1.
- R4: A forwarded access in 0xFFEE0000–0xFFEFFFFF drives n_upper_o (address lines [23:17], bit 0 = line 17) to its address bits [23:17] with bit 3 (line 20) forced to 1.
- R5: A valid wide access to 0xFFF80000–0xFFFDFFFF is forwarded with rom_cs_o only when cfg_ext_en_i is captured as 1. n_upper_o[6:3] (lines 23:20) is then 4'b1111 and n_upper_o[2:0] equals address bits [19:17].
- R6: disc_o is 1 exactly when fwd_o is 1 and w_burst_rd_i is 1.
- R7: A valid narrow access to 0x0E0000–0x0FFFFF asserts rom_cs_o under the same half enables as R2/R3. This happens only when n_refresh_i and n_dma_i are both 0.
- R8: Narrow accesses never assert fwd_o or disc_o, including narrow addresses in the extended region.
- R9: Outside the ROM windows, or with no valid access, rom_cs_o and fwd_o are 0. n_upper_o is 0 whenever fwd_o is 0. A forwarded base-window access carries its own address bits [23:17].
- R10: A change on a configuration input takes effect on the decode only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_lo_en_i | input | 1 | Lower 64 KB half enable |
| cfg_hi_gate_i | input | HI_GATES | Upper half gate bits, all must be set |
| cfg_ext_en_i | input | 1 | Extended 384 KB region enable |
| w_valid_i | input | 1 | Wide-bus memory access present |
| w_addr_i | input | WIDE_AW | Wide-bus address |
| w_burst_rd_i | input | 1 | Wide access is a burst read |
| n_valid_i | input | 1 | Narrow-bus memory access present |
| n_addr_i | input | NARROW_AW | Narrow-bus address |
| n_refresh_i | input | 1 | Narrow cycle is a refresh |
| n_dma_i | input | 1 | Narrow cycle is a DMA transfer |
| fwd_o | output | 1 | Wide access is forwarded to the narrow bus |
| rom_cs_o | output | 1 | ROM chip select |
| n_upper_o | output | 7 | Narrow address lines [23:17] for a forwarded cycle |
| disc_o | output | 1 | Disconnect after first data phase |

## Verification
On every cycle the assertions check four things: disconnect implies forward, narrow cycles never forward, refresh and DMA suppress the narrow chip select, and the idle upper lines are zero. They also check the forced line 20 in the 1 MB-down mirror and the all-ones lines in the extended region. Some behaviour only the bench sweep can show. That covers the per-half enables across all three mirrors, each window boundary address, and the way gate and extended enables combine. It also covers the one-clock delay before a configuration change takes effect.

// File: rtl/rom_win_pkg.sv
package rom_win_pkg;
  localparam int unsigned WIDE_AW   = 32;
  localparam int unsigned NARROW_AW = 24;
  localparam int unsigned UP_LSB    = 17;
  localparam int unsigned UP_MSB    = 23;
  localparam int unsigned UP_W      = UP_MSB - UP_LSB + 1;
  // 128 KB block tags (address >> 17)
  localparam logic [14:0] TAG_BASE  = 15'h0007;
  localparam logic [14:0] TAG_TOP   = 15'h7FFF;
  localparam logic [14:0] TAG_M1M   = 15'h7FF7;
  // 512 KB block tag (address >> 19) holding the extended region
  localparam logic [12:0] TAG_EXT   = 13'h1FFF;
  localparam logic [UP_W-1:0] FORCE_L20 = UP_W'(1) << (20 - UP_LSB);
  localparam logic [UP_W-1:0] FORCE_EXT = UP_W'(4'hF) << (20 - UP_LSB);

  typedef struct packed {
    logic lo;
    logic hi;
    logic ext;
  } rom_en_t;
endpackage

// File: rtl/rom_cfg_regs.sv
module rom_cfg_regs
  import rom_win_pkg::*;
#(
  parameter int unsigned HI_GATES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lo_en_i,
  input  logic [HI_GATES-1:0] hi_gate_i,
  input  logic                ext_en_i,
  output rom_en_t             en_o
);
  logic [HI_GATES-1:0] gate_q;
  logic                lo_q, ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= 1'b0;
      ext_q  <= 1'b0;
      gate_q <= '0;
    end else begin
      lo_q   <= lo_en_i;
      ext_q  <= ext_en_i;
      gate_q <= hi_gate_i;
    end
  end

  assign en_o.lo  = lo_q;
  assign en_o.hi  = &gate_q;
  assign en_o.ext = ext_q;
endmodule

// File: rtl/rom_wide_dec.sv
module rom_wide_dec
  import rom_win_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  rom_en_t            en_i,
  input  logic               valid_i,
  input  logic [WIDE_AW-1:0] addr_i,
  input  logic               burst_rd_i,
  output logic               fwd_o,
  output logic [UP_W-1:0]    upper_o,
  output logic               disc_o
);
  logic [14:0] tag;
  logic        in_base, in_top, in_m1m, in_ext, half_hi, win_ok;
  logic [15:0] unused_lo;

  assign tag       = addr_i[WIDE_AW-1:UP_LSB];
  assign half_hi   = addr_i[16];
  assign unused_lo = addr_i[15:0];
  assign in_base   = (tag == TAG_BASE);
  assign in_top    = (tag == TAG_TOP);
  assign in_m1m    = (tag == TAG_M1M);
  // 0xFFF80000-0xFFFDFFFF: the 512 KB block minus its top 128 KB
  assign in_ext    = (addr_i[WIDE_AW-1:19] == TAG_EXT) && (addr_i[18:17] != 2'b11);

  always_comb begin
    win_ok = 1'b0;
    if (in_base || in_top || in_m1m) win_ok = half_hi ? en_i.hi : en_i.lo;
    else if (in_ext)                 win_ok = en_i.ext;
  end

  assign fwd_o  = valid_i && win_ok;
  assign disc_o = fwd_o && burst_rd_i;

  always_comb begin
    upper_o = '0;
    if (fwd_o) begin
      upper_o = addr_i[UP_MSB:UP_LSB];
      if (in_m1m) upper_o = upper_o | FORCE_L20;
      if (in_ext) upper_o = upper_o | FORCE_EXT;
    end
  end

  AST_DISC_NEEDS_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disc_o |-> (fwd_o && burst_rd_i)); // R6
  AST_FWD_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |-> valid_i); // R9
endmodule

// File: rtl/rom_narrow_dec.sv
module rom_narrow_dec
  import rom_win_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  rom_en_t              en_i,
  input  logic                 valid_i,
  input  logic [NARROW_AW-1:0] addr_i,
  input  logic                 refresh_i,
  input  logic                 dma_i,
  output logic                 cs_o
);
  logic        in_win, half_ok;
  logic [15:0] unused_lo;

  assign unused_lo = addr_i[15:0];
  assign in_win    = (addr_i[NARROW_AW-1:UP_LSB] == TAG_BASE[NARROW_AW-UP_LSB-1:0]);
  assign half_ok   = addr_i[16] ? en_i.hi : en_i.lo;
  assign cs_o      = valid_i && !refresh_i && !dma_i && in_win && half_ok;

  AST_NARROW_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh_i || dma_i) |-> !cs_o); // R7
endmodule

// File: rtl/rom_win_dec.sv
module rom_win_dec
  import rom_win_pkg::*;
#(
  parameter int unsigned HI_GATES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_lo_en_i,
  input  logic [HI_GATES-1:0]  cfg_hi_gate_i,
  input  logic                 cfg_ext_en_i,
  input  logic                 w_valid_i,
  input  logic [WIDE_AW-1:0]   w_addr_i,
  input  logic                 w_burst_rd_i,
  input  logic                 n_valid_i,
  input  logic [NARROW_AW-1:0] n_addr_i,
  input  logic                 n_refresh_i,
  input  logic                 n_dma_i,
  output logic                 fwd_o,
  output logic                 rom_cs_o,
  output logic [6:0]           n_upper_o,
  output logic                 disc_o
);
  rom_en_t en;
  logic    n_cs;

  rom_cfg_regs #(.HI_GATES(HI_GATES)) u_cfg (
    .clk_i, .rst_ni,
    .lo_en_i(cfg_lo_en_i), .hi_gate_i(cfg_hi_gate_i), .ext_en_i(cfg_ext_en_i),
    .en_o(en)
  );

  rom_wide_dec u_wide (
    .clk_i, .rst_ni, .en_i(en),
    .valid_i(w_valid_i), .addr_i(w_addr_i), .burst_rd_i(w_burst_rd_i),
    .fwd_o(fwd_o), .upper_o(n_upper_o), .disc_o(disc_o)
  );

  rom_narrow_dec u_narrow (
    .clk_i, .rst_ni, .en_i(en),
    .valid_i(n_valid_i), .addr_i(n_addr_i),
    .refresh_i(n_refresh_i), .dma_i(n_dma_i), .cs_o(n_cs)
  );

  assign rom_cs_o = fwd_o || n_cs;

  AST_NARROW_NO_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_valid_i && !w_valid_i) |-> (!fwd_o && !disc_o)); // R8
  AST_IDLE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fwd_o |-> (n_upper_o == 7'd0)); // R9
  AST_M1M_LINE20: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_o && w_addr_i[31:17] == 15'h7FF7) |-> n_upper_o[3]); // R4
  AST_EXT_LINES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_o && w_addr_i[31:19] == 13'h1FFF) |-> (n_upper_o[6:3] == 4'hF)); // R5
endmodule

// File: tb/rom_win_dec_test.sv
module rom_win_dec_test;
  logic        clk_i = 0, rst_ni = 0;
  logic        cfg_lo_en_i = 0, cfg_ext_en_i = 0;
  logic [1:0]  cfg_hi_gate_i = 0;
  logic        w_valid_i = 0, w_burst_rd_i = 0;
  logic [31:0] w_addr_i = 0;
  logic        n_valid_i = 0, n_refresh_i = 0, n_dma_i = 0;
  logic [23:0] n_addr_i = 0;
  logic        fwd_o, rom_cs_o, disc_o;
  logic [6:0]  n_upper_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  rom_win_dec uut (.*);

  localparam logic [31:0] WPTS [24] = '{
    32'h000E0000, 32'h000E8123, 32'h000EFFFF, 32'h000F0000, 32'h000FFFFF, 32'h000DFFFF,
    32'h00100000, 32'hFFFE0000, 32'hFFFEFFFF, 32'hFFFF0000, 32'hFFFFFFFF, 32'hFFEE0000,
    32'hFFEE4444, 32'hFFEF0000, 32'hFFEFFFFF, 32'hFFEDFFFF, 32'hFFF00000, 32'hFFF80000,
    32'hFFFA5678, 32'hFFFDFFFF, 32'hFFF7FFFF, 32'h00FE0000, 32'h00FF0000, 32'h800E0000};
  localparam logic [23:0] NPTS [10] = '{
    24'h0E0000, 24'h0EFFFF, 24'h0F0000, 24'h0FFFFF, 24'h0DFFFF,
    24'h100000, 24'hFE0000, 24'hFF0000, 24'hF80000, 24'h0F8000};

  function automatic bit in_rng(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
    return a >= lo && a <= hi;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(bit lo, logic [1:0] hg, bit ext);
    @(negedge clk_i);
    cfg_lo_en_i = lo; cfg_hi_gate_i = hg; cfg_ext_en_i = ext;
    @(posedge clk_i); #2;
  endtask

  task automatic wide_probe(logic [31:0] a, bit burst, bit lo, bit hi, bit ext);
    bit lo_hit, hi_hit, ex_hit, m1m, fwd;
    logic [6:0] up;
    lo_hit = in_rng(a, 32'h000E0000, 32'h000EFFFF) || in_rng(a, 32'hFFFE0000, 32'hFFFEFFFF)
          || in_rng(a, 32'hFFEE0000, 32'hFFEEFFFF);
    hi_hit = in_rng(a, 32'h000F0000, 32'h000FFFFF) || in_rng(a, 32'hFFFF0000, 32'hFFFFFFFF)
          || in_rng(a, 32'hFFEF0000, 32'hFFEFFFFF);
    ex_hit = in_rng(a, 32'hFFF80000, 32'hFFFDFFFF);
    m1m    = in_rng(a, 32'hFFEE0000, 32'hFFEFFFFF);
    fwd    = (lo_hit && lo) || (hi_hit && hi) || (ex_hit && ext);
    up     = fwd ? 7'((a >> 17) & 32'h7F) : 7'd0;
    if (fwd && m1m) up = up | 7'h08;
    if (fwd && ex_hit) up = up | 7'h78;
    w_addr_i = a; w_burst_rd_i = burst; w_valid_i = 1;
    #1;
    chk(lo_hit ? "R2" : hi_hit ? "R3" : ex_hit ? "R5" : "R9", {31'd0, fwd_o}, {31'd0, fwd}, "fwd");
    chk("R2", {31'd0, rom_cs_o}, {31'd0, fwd}, "cs");
    chk(m1m ? "R4" : ex_hit ? "R5" : "R9", {25'd0, n_upper_o}, {25'd0, up}, "upper");
    chk("R6", {31'd0, disc_o}, {31'd0, fwd && burst}, "disc");
    w_valid_i = 0;
    #1;
  endtask

  task automatic narrow_probe(logic [23:0] a, bit rf, bit dm, bit lo, bit hi);
    bit cs;
    cs = !rf && !dm && ((a >= 24'h0E0000 && a <= 24'h0EFFFF && lo) ||
                        (a >= 24'h0F0000 && a <= 24'h0FFFFF && hi));
    n_addr_i = a; n_refresh_i = rf; n_dma_i = dm; n_valid_i = 1;
    #1;
    chk("R7", {31'd0, rom_cs_o}, {31'd0, cs}, "narrow cs");
    chk("R8", {30'd0, fwd_o, disc_o}, 32'd0, "narrow fwd/disc");
    n_valid_i = 0; n_refresh_i = 0; n_dma_i = 0;
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state with config inputs already asking for everything
    cfg_lo_en_i = 1; cfg_hi_gate_i = 2'b11; cfg_ext_en_i = 1;
    #23;
    w_valid_i = 1; w_addr_i = 32'hFFFF0000; #1;
    chk("R1", {31'd0, rom_cs_o}, 32'd0, "cs in reset");
    chk("R1", {31'd0, fwd_o}, 32'd0, "fwd in reset");
    w_valid_i = 0; n_valid_i = 1; n_addr_i = 24'h0E0000; #1;
    chk("R1", {31'd0, rom_cs_o}, 32'd0, "narrow cs in reset");
    n_valid_i = 0;
    cfg_lo_en_i = 0; cfg_hi_gate_i = 0; cfg_ext_en_i = 0;
    @(negedge clk_i); rst_ni = 1;

    for (int c = 0; c < 16; c++) begin
      bit lo, ext, hi;
      logic [1:0] hg;
      lo = c[0]; hg = c[2:1]; ext = c[3]; hi = &hg;
      set_cfg(lo, hg, ext);
      foreach (WPTS[i]) begin
        wide_probe(WPTS[i], 1'b0, lo, hi, ext);
        wide_probe(WPTS[i], 1'b1, lo, hi, ext);
      end
      foreach (NPTS[i])
        for (int m = 0; m < 4; m++) narrow_probe(NPTS[i], m[0], m[1], lo, hi);
    end

    // R10: change takes effect only after the next rising edge
    set_cfg(1'b0, 2'b00, 1'b0);
    @(negedge clk_i);
    cfg_lo_en_i = 1; cfg_ext_en_i = 1;
    w_valid_i = 1; w_addr_i = 32'h000E1000; #1;
    chk("R10", {31'd0, rom_cs_o}, 32'd0, "before edge");
    @(posedge clk_i); #2;
    chk("R10", {31'd0, rom_cs_o}, 32'd1, "after edge");
    @(negedge clk_i);
    cfg_lo_en_i = 0; #1;
    chk("R10", {31'd0, rom_cs_o}, 32'd1, "disable before edge");
    @(posedge clk_i); #2;
    chk("R10", {31'd0, rom_cs_o}, 32'd0, "disable after edge");
    w_valid_i = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule